// File: doc/BRIEF.md
# Serial Converter Control and Result Port

This block is the device-side digital front end of a serial successive-approximation converter. The host drives chip select (active low), a serial clock and a serial data line. The block samples all three against a fast system clock. It hunts for a start bit and collects an eight-bit control word. On the serial clock falling edge that closes that word, it asks the converter core for a sample. It then shifts the result back out on the serial data output, most significant bit first.

The converter core is not part of the block. At the moment the conversion starts, the block pulses `conv_req` for one system clock, shows the captured control word, and takes the parallel `sample_data` word in the same cycle. The block tracks the power mode requested in the control word and honours an active-low hardware shutdown. It does not drive high impedance itself: it gives separate output-enable signals for the data output and the strobe. A new control word may start while the tail of the previous result is still leaving, so back-to-back conversions need only 16 serial clocks each.

Top module: `serial_adc_slave`

## Requirements
- R1: With chip select low, the block idle and shutdown inactive, DIN bits sampled as 0 on serial clock rising edges are ignored. The first 1 sampled is the start bit.
- R2: The start bit and the next seven DIN bits form the control word, first-received bit in `ctl_byte[7]`, so `ctl_byte[7]` is always 1. `ctl_byte` is valid while `conv_req` is high.
- R3: The conversion starts on the first serial clock falling edge after the eighth control bit. At that edge `conv_req` pulses for one system clock and `sample_data` is captured. No conversion starts at any other time.
- R4: `strb` is high from that falling edge until the next falling edge, exactly one serial clock period.
- R5: On the 12 falling edges after the start edge, `dout` carries the 10-bit result MSB first, followed by two 0 bits. `dout` then stays 0 until the next result.
- R6: Before any conversion, and after an aborted one, `dout` shifts out zeros.
- R7: While chip select is high, `dout_oe` and `strb_oe` are 0 and the block returns to idle, discarding any partial control word or result. After chip select falls again, `strb` is driven 0.
- R8: While a result is shifting out, a 1 on DIN is ignored until the falling edge that drives frame bit B4 (the 8th data edge). The first 1 sampled after that edge is a new start bit, which gives one conversion every 16 serial clocks.
- R9: `pwr_state` encodes 2'b11 on, 2'b01 fast standby, 2'b00 full power-down, 2'b10 hardware off. The reset value is on. Each conversion start sets on. Control bits [1:0] request a mode (00 full power-down, 01 fast standby, 10 or 11 on), applied at the 12th data falling edge.
- R10: While `shdn_n` is low, `pwr_state` reads hardware off and DIN is ignored. Any conversion and result in progress are aborted, with `strb` and `dout` forced to 0. On release the software mode is on.
- R11: DIN is sampled only on serial clock rising edges, and `dout` changes only on falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data in |
| shdn_n | input | 1 | Hardware shutdown, active low |
| sample_data | input | RES_W | Parallel result from the converter core |
| conv_req | output | 1 | One-cycle sample/convert request |
| ctl_byte | output | CTL_W | Control word of the conversion being started |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for dout |
| strb | output | 1 | Conversion strobe |
| strb_oe | output | 1 | Output enable for strb |
| pwr_state | output | 2 | Effective power mode |

## Verification
On every cycle the assertions check these properties. The output bit holds still between falling edges. The strobe lasts a single serial period and comes up together with each conversion request. Every captured word carries its start bit at the top. Shutdown silences the strobe, the request and the output. The software power mode moves only at a conversion start or completion. Only the bench scenarios can show that the right bit reaches `dout` on the right edge, and that the 16-clock overlap accepts its start bit at the B4 boundary but not one bit earlier. They also show that a chip-select release or a shutdown mid-frame leaves zeros behind, and that the requested power mode lands on the 12th edge.

// File: rtl/adc_sif_pkg.sv
`timescale 1ns/1ps
package adc_sif_pkg;

  localparam int unsigned CTL_BITS   = 8;
  localparam int unsigned RES_BITS   = 10;
  localparam int unsigned FRAME_BITS = 12;
  localparam int unsigned OVL_BIT    = 4;

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_CAPT = 2'd1,
    RX_ARMD = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    PS_FULL  = 2'b00,
    PS_FAST  = 2'b01,
    PS_HWOFF = 2'b10,
    PS_ON    = 2'b11
  } pwr_state_e;

  function automatic pwr_state_e pm_decode(input logic [1:0] pm);
    pwr_state_e m;
    case (pm)
      2'b00:   m = PS_FULL;
      2'b01:   m = PS_FAST;
      default: m = PS_ON;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sif_sclk_edge.sv
`timescale 1ns/1ps
module sif_sclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic sclk_rise,
  output logic sclk_fall
);

  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;

endmodule

// File: rtl/sif_ctrl_rx.sv
`timescale 1ns/1ps
module sif_ctrl_rx
  import adc_sif_pkg::*;
#(
  parameter int unsigned CTL_W = CTL_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             din,
  input  logic             hunt_ok,
  output logic             load,
  output logic             conv_req,
  output logic [CTL_W-1:0] ctl_byte,
  output logic [1:0]       pm_now
);

  localparam int unsigned CNT_W = $clog2(CTL_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CTL_W - 1);

  rx_state_e        st_q, st_d;
  logic [CTL_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q;
  logic [CTL_W-1:0] ctl_q;

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    load  = 1'b0;
    if (clear) begin
      st_d  = RX_HUNT;
      cnt_d = '0;
    end else begin
      case (st_q)
        RX_HUNT: begin
          if (sclk_rise && din && hunt_ok) begin
            st_d  = RX_CAPT;
            sh_d  = {sh_q[CTL_W-2:0], 1'b1};
            cnt_d = CNT_W'(1);
          end
        end
        RX_CAPT: begin
          if (sclk_rise) begin
            sh_d  = {sh_q[CTL_W-2:0], din};
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == LAST_CNT) st_d = RX_ARMD;
          end
        end
        RX_ARMD: begin
          if (sclk_fall) begin
            load  = 1'b1;
            st_d  = RX_HUNT;
            cnt_d = '0;
          end
        end
        default: st_d = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_HUNT;
      sh_q  <= '0;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      req_q <= load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_q <= '0;
    else if (load) ctl_q <= sh_q;
  end

  assign conv_req = req_q;
  assign ctl_byte = ctl_q;
  assign pm_now   = sh_q[1:0];

  // R2
  ctl_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ctl_q[CTL_W-1]);

endmodule

// File: rtl/sif_result_shift.sv
`timescale 1ns/1ps
module sif_result_shift
  import adc_sif_pkg::*;
#(
  parameter int unsigned RES_W   = RES_BITS,
  parameter int unsigned FRAME_W = FRAME_BITS,
  parameter int unsigned OVL_B   = OVL_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sclk_fall,
  input  logic             load,
  input  logic [RES_W-1:0] sample_data,
  output logic             dout,
  output logic             strb,
  output logic             hunt_ok,
  output logic             conv_done
);

  localparam int unsigned FCNT_W = $clog2(FRAME_W + 1);
  localparam logic [FCNT_W-1:0] LAST_CNT = FCNT_W'(FRAME_W - 1);
  localparam logic [FCNT_W-1:0] OVL_CNT  = FCNT_W'(FRAME_W - OVL_B);

  logic [FRAME_W-1:0] load_word;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [FCNT_W-1:0]  fcnt_q, fcnt_d;
  logic               busy_q, busy_d;
  logic               dout_q, dout_d;
  logic               strb_q, strb_d;
  logic               done;

  generate
    if (FRAME_W > RES_W) begin : g_pad
      assign load_word = {sample_data, {(FRAME_W - RES_W){1'b0}}};
    end else if (FRAME_W == RES_W) begin : g_exact
      assign load_word = sample_data;
    end else begin : g_trunc
      assign load_word = sample_data[RES_W-1 -: FRAME_W];
    end
  endgenerate

  always_comb begin
    frame_d = frame_q;
    fcnt_d  = fcnt_q;
    busy_d  = busy_q;
    dout_d  = dout_q;
    strb_d  = strb_q;
    done    = 1'b0;
    if (clear) begin
      frame_d = '0;
      fcnt_d  = '0;
      busy_d  = 1'b0;
      dout_d  = 1'b0;
      strb_d  = 1'b0;
    end else if (sclk_fall) begin
      dout_d = frame_q[FRAME_W-1];
      strb_d = load;
      if (load) begin
        frame_d = load_word;
        fcnt_d  = '0;
        busy_d  = 1'b1;
      end else begin
        frame_d = {frame_q[FRAME_W-2:0], 1'b0};
        if (busy_q) begin
          fcnt_d = fcnt_q + FCNT_W'(1);
          if (fcnt_q == LAST_CNT) begin
            busy_d = 1'b0;
            done   = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      fcnt_q  <= '0;
      busy_q  <= 1'b0;
      dout_q  <= 1'b0;
      strb_q  <= 1'b0;
    end else begin
      frame_q <= frame_d;
      fcnt_q  <= fcnt_d;
      busy_q  <= busy_d;
      dout_q  <= dout_d;
      strb_q  <= strb_d;
    end
  end

  assign hunt_ok   = !busy_q || (fcnt_q >= OVL_CNT);
  assign conv_done = done;
  assign dout      = dout_q;
  assign strb      = strb_q;

  // R11
  dout_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !clear) |=> $stable(dout_q));

  // R4
  strb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_q && sclk_fall && !clear) |=> !strb_q);

endmodule

// File: rtl/sif_power_ctl.sv
`timescale 1ns/1ps
module sif_power_ctl
  import adc_sif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_n,
  input  logic       load,
  input  logic       conv_done,
  input  logic [1:0] pm_req,
  output logic [1:0] pwr_state
);

  pwr_state_e soft_q, soft_d;
  logic [1:0] pend_q;

  always_comb begin
    soft_d = soft_q;
    if (!shdn_n)        soft_d = PS_ON;
    else if (load)      soft_d = PS_ON;
    else if (conv_done) soft_d = pm_decode(pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= PS_ON;
    else        soft_q <= soft_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_q <= 2'b11;
    else if (load) pend_q <= pm_req;
  end

  assign pwr_state = shdn_n ? soft_q : PS_HWOFF;

  // R10
  hw_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (soft_q == PS_ON));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_n && !load && !conv_done) |=> $stable(soft_q));

endmodule

// File: rtl/serial_adc_slave.sv
`timescale 1ns/1ps
module serial_adc_slave
  import adc_sif_pkg::*;
#(
  parameter int unsigned RES_W   = RES_BITS,
  parameter int unsigned FRAME_W = FRAME_BITS,
  parameter int unsigned CTL_W   = CTL_BITS,
  parameter int unsigned OVL_B   = OVL_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic             shdn_n,
  input  logic [RES_W-1:0] sample_data,
  output logic             conv_req,
  output logic [CTL_W-1:0] ctl_byte,
  output logic             dout,
  output logic             dout_oe,
  output logic             strb,
  output logic             strb_oe,
  output logic [1:0]       pwr_state
);

  logic rst_meta, rst_sync;
  logic sclk_rise, sclk_fall;
  logic clear, load, hunt_ok, conv_done;
  logic [1:0] pm_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign clear = cs_n | ~shdn_n;

  sif_sclk_edge i_edge (
    .clk       (clk),
    .rst_n     (rst_sync),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  sif_ctrl_rx #(.CTL_W(CTL_W)) i_rx (
    .clk       (clk),
    .rst_n     (rst_sync),
    .clear     (clear),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .din       (din),
    .hunt_ok   (hunt_ok),
    .load      (load),
    .conv_req  (conv_req),
    .ctl_byte  (ctl_byte),
    .pm_now    (pm_now)
  );

  sif_result_shift #(.RES_W(RES_W), .FRAME_W(FRAME_W), .OVL_B(OVL_B)) i_shift (
    .clk         (clk),
    .rst_n       (rst_sync),
    .clear       (clear),
    .sclk_fall   (sclk_fall),
    .load        (load),
    .sample_data (sample_data),
    .dout        (dout),
    .strb        (strb),
    .hunt_ok     (hunt_ok),
    .conv_done   (conv_done)
  );

  sif_power_ctl i_pwr (
    .clk       (clk),
    .rst_n     (rst_sync),
    .shdn_n    (shdn_n),
    .load      (load),
    .conv_done (conv_done),
    .pm_req    (pm_now),
    .pwr_state (pwr_state)
  );

  assign dout_oe = ~cs_n;
  assign strb_oe = ~cs_n;

  // R4
  strb_with_req_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    conv_req |-> strb);

  // R10
  shdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !shdn_n |=> (!strb && !conv_req && !dout));

endmodule

// File: tb/test_serial_adc_slave.sv
`timescale 1ns/1ps
module test_serial_adc_slave;

  localparam int NMAX = 256;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sclk, din, shdn_n;
  logic [9:0] sample_data;
  logic       conv_req, dout, dout_oe, strb, strb_oe;
  logic [7:0] ctl_byte;
  logic [1:0] pwr_state;

  int n_chk = 0, n_err = 0, r11_bad = 0, conv_n = 0;
  bit finished = 1'b0;
  logic [7:0] conv_log [0:63];

  bit         sd [NMAX];
  bit         ed [NMAX];
  bit         es [NMAX];
  bit         hr [NMAX];
  logic [9:0] sres [NMAX];
  logic [1:0] ep [NMAX];
  int         ec [NMAX];
  logic [7:0] ectl [0:15];
  int         nexp;
  logic [1:0] cur_pwr;
  int unsigned seed_dummy;

  always #2.5 clk = ~clk;

  serial_adc_slave i_serial_adc_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .shdn_n(shdn_n), .sample_data(sample_data), .conv_req(conv_req),
    .ctl_byte(ctl_byte), .dout(dout), .dout_oe(dout_oe), .strb(strb),
    .strb_oe(strb_oe), .pwr_state(pwr_state)
  );

  always @(negedge clk) begin
    if (conv_req === 1'b1) begin
      if (conv_n < 64) conv_log[conv_n] = ctl_byte;
      conv_n++;
    end
  end

  function automatic logic [1:0] mode_of(input logic [1:0] pm);
    if (pm == 2'b00) return 2'b00;
    if (pm == 2'b01) return 2'b01;
    return 2'b11;
  endfunction

  function automatic bit frame_bit(input logic [9:0] res, input int k);
    if (k <= 10) return res[10-k];
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sck(input logic d);
    logic pre;
    @(negedge clk); din = d;
    repeat (2) @(negedge clk);
    pre = dout;
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    if (dout !== pre) r11_bad++;
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_stream();
    for (int c = 0; c < NMAX; c++) begin
      sd[c] = 0; ed[c] = 0; es[c] = 0; hr[c] = 0; sres[c] = '0;
      ep[c] = cur_pwr; ec[c] = 0;
    end
    nexp = 0;
  endtask

  task automatic add_conv(input int s, input logic [7:0] ctl, input logic [9:0] res);
    for (int i = 0; i < 8; i++) sd[s+i] = ctl[7-i];
    hr[s+7] = 1; sres[s+7] = res; es[s+7] = 1;
    for (int k = 1; k <= 12; k++) ed[s+7+k] = frame_bit(res, k);
    for (int c = s + 7; c < NMAX; c++) begin
      ec[c]++;
      ep[c] = (c < s + 19) ? 2'b11 : mode_of(ctl[1:0]);
    end
    ectl[nexp] = ctl;
    nexp++;
  endtask

  task automatic play(input int n, input string dtag);
    int base;
    base = conv_n;
    for (int c = 0; c < n; c++) begin
      sample_data = hr[c] ? sres[c] : 10'($urandom);
      sck(sd[c]);
      #1;
      chk(dout === ed[c], dtag, $sformatf("dout call %0d", c), int'(dout), int'(ed[c]));
      chk(strb === es[c], "R4", $sformatf("strb call %0d", c), int'(strb), int'(es[c]));
      chk(conv_n - base == ec[c], "R3", $sformatf("conv count call %0d", c), conv_n - base, ec[c]);
      chk(pwr_state === ep[c], "R9", $sformatf("pwr call %0d", c), int'(pwr_state), int'(ep[c]));
    end
    for (int j = 0; j < nexp; j++)
      if (base + j < 64)
        chk(conv_log[base+j] === ectl[j], "R2", $sformatf("ctl word %0d", j),
            int'(conv_log[base+j]), int'(ectl[j]));
    cur_pwr = ep[n-1];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int s, base;
    logic [7:0] ctl;
    logic [9:0] res;
    seed_dummy = $urandom(32'd7731);
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; shdn_n = 1'b1;
    sample_data = '0; cur_pwr = 2'b11;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk(dout_oe === 1'b0, "R7", "dout_oe reset", int'(dout_oe), 0);
    chk(strb_oe === 1'b0, "R7", "strb_oe reset", int'(strb_oe), 0);
    chk(conv_req === 1'b0, "R3", "conv_req reset", int'(conv_req), 0);
    chk(pwr_state === 2'b11, "R9", "pwr reset", int'(pwr_state), 3);
    chk(dout === 1'b0, "R6", "dout reset", int'(dout), 0);

    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(strb === 1'b0 && strb_oe === 1'b1, "R7", "strb low after select", int'(strb), 0);

    // zeros only: nothing starts, dout stays 0
    clear_stream();
    play(8, "R6");
    chk(conv_n == 0, "R1", "no start on zeros", conv_n, 0);

    // separate conversions with leading zeros and blocked noise
    clear_stream();
    base = conv_n;
    s = 1 + int'($urandom % 4);
    for (int j = 0; j < 6; j++) begin
      ctl = {1'b1, 7'($urandom)};
      res = 10'($urandom);
      if (j == 0) res = 10'h3FF;
      if (j == 1) res = 10'h000;
      if (j == 2) res = 10'h201;
      add_conv(s, ctl, res);
      sd[s + 8 + int'($urandom % 8)] = 1'b1;
      s += 20 + int'($urandom % 4);
    end
    play(s + 4, "R5");
    chk(conv_n - base == 6, "R1", "start bits found", conv_n - base, 6);

    // back-to-back conversions at 16-clock cadence
    clear_stream();
    base = conv_n;
    s = 2;
    for (int j = 0; j < 4; j++) begin
      ctl = {1'b1, 7'($urandom)};
      if (j == 1) ctl[1:0] = 2'b00;
      add_conv(s, ctl, 10'($urandom));
      if (j > 0) sd[s-1] = 1'b1;
      s += 16;
    end
    play(s + 8, "R8");
    chk(conv_n - base == 4, "R8", "overlapped conversions", conv_n - base, 4);

    // chip select released mid-result
    clear_stream();
    add_conv(0, 8'b1100_0111, 10'h2AB);
    play(12, "R5");
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout_oe === 1'b0, "R7", "dout_oe deselected", int'(dout_oe), 0);
    chk(strb_oe === 1'b0, "R7", "strb_oe deselected", int'(strb_oe), 0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(strb === 1'b0 && strb_oe === 1'b1, "R7", "strb low after reselect", int'(strb), 0);
    clear_stream();
    play(16, "R7");

    // chip select released mid control word
    sck(1'b1); sck(1'b0); sck(1'b1);
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    clear_stream();
    add_conv(2, 8'b1010_0111, 10'h155);
    play(25, "R7");

    // hardware shutdown while strobe is high
    clear_stream();
    add_conv(0, 8'b1000_0000, 10'h3C3);
    play(8, "R5");
    base = conv_n;
    shdn_n = 1'b0;
    @(negedge clk); #1;
    chk(pwr_state === 2'b10, "R10", "pwr hardware off", int'(pwr_state), 2);
    chk(strb === 1'b0, "R10", "strb aborted", int'(strb), 0);
    for (int i = 0; i < 10; i++) sck(1'b1);
    chk(conv_n == base, "R10", "din ignored in shutdown", conv_n - base, 0);
    chk(dout === 1'b0, "R10", "dout in shutdown", int'(dout), 0);
    @(negedge clk); shdn_n = 1'b1;
    repeat (2) @(negedge clk);
    cur_pwr = 2'b11;
    clear_stream();
    play(16, "R10");

    chk(r11_bad == 0, "R11", "dout moved during sclk high", r11_bad, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule